// File: doc/BRIEF.md
# Row-Buffered Bit-Cell Memory Array

This block models a memory built from bit cells arranged as a grid of rows and columns. The request address has two fields. The upper field picks a row through a one-hot word-line decoder. The lower field picks a column. A read does not index a stored word directly. It first copies the whole selected row into a row buffer, and a column selector then picks the addressed bit out of that buffer. A wider data word comes from identical bit planes placed side by side. Every plane gets the same row and column, and each plane supplies one bit of the word.

The row buffer keeps the last activated row. A read whose row is already held skips the activation step and returns one cycle sooner. Writes go straight to the addressed cell in every plane. When the written row is the buffered one, the buffer is updated in the same cycle, so later reads see the new value. While a row activation is in flight the block reports busy, and it ignores any request presented during that time.

Top module: `rowbuf_mem`

## Requirements
- R1: The address is `{row, column}`: the upper `clog2(ROWS)` bits select the row and the lower `clog2(COLS)` bits select the column. Two addresses that differ only in their low bits share a row.
- R2: The row decoder drives exactly one word line for any in-range row number. Distinct addresses never alias: each holds its own value.
- R3: A read whose row is not buffered and that is accepted at clock edge k raises `rd_valid` for the single cycle after edge k+1. `rd_data` then carries the addressed word.
- R4: A read whose row is held in the valid row buffer and that is accepted at edge k raises `rd_valid` for the cycle after edge k, with the addressed word.
- R5: `busy` is high for exactly the one cycle between the two edges of a row activation. A request presented while `busy` is high is ignored: a write does not change the memory and a read produces no `rd_valid`.
- R6: An accepted write stores `wdata[p]` into the addressed cell of plane p, for every plane. A read returns plane p's cell on `rd_data[p]`.
- R7: A write to the buffered row updates the buffer in the same cycle. A following read of that row is still a hit (R4 timing) and returns the new value.
- R8: Reset clears the row-buffer valid flag, so the first read after reset always takes the activation path (R3 timing). After reset `rd_valid` and `busy` are low.
- R9: `rd_valid` is high only in the cycle that returns read data. An accepted write never raises it.
- R10: A write to a row other than the buffered one leaves the buffered row in place, so a read of the buffered row remains a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | clog2(ROWS)+clog2(COLS) | Address, row field in the upper bits |
| req_wdata | input | PLANES | Write word, one bit per plane |
| rd_data | output | PLANES | Read word, one bit per plane |
| rd_valid | output | 1 | Read data valid, one cycle per read |
| busy | output | 1 | Row activation in flight; requests ignored |

## Verification
The bench builds the block with 8 rows, 4 columns and 8 planes. That gives a 3-bit row field over a 2-bit column field and 32 distinct 8-bit words. With this size, unique per-address data can expose row or column aliasing and a swapped address split. It also makes hit and miss sequences over several rows and columns of one row cheap to reach. Random traffic, with latency predicted from a bench model of the buffered row, is mixed with directed cases: a request during busy, a write hit followed by a read, a write to another row, and reset in the middle of a run.

// File: rtl/rbm_pkg.sv
// Package: shared types for the row-buffered memory array.
// Assumes nothing beyond the standard language.
package rbm_pkg;

    // Controller phase: idle, or the middle of a row activation.
    typedef enum logic {
        RBM_IDLE     = 1'b0,
        RBM_ACTIVATE = 1'b1
    } rbm_state_e;

endpackage

// File: rtl/rbm_onehot_decoder.sv
// Module: rbm_onehot_decoder
// Turns a binary index into a one-hot select vector. It serves as the row
// (word-line) decoder and as the column decoder.
// Assumes N >= 2. An index at or above N gives an all-zero vector.
module rbm_onehot_decoder #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     sel
);

    // One comparator per output line.
    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            assign sel[i] = (idx == IDX_W'(i));
        end
    endgenerate

    // Guard: an in-range index drives exactly one line.
    always_comb begin : p_guard
        if (32'(idx) < N) begin
            AST_WL_ONEHOT: assert ($onehot(sel)) else $error("decoder line count wrong"); // R2
        end
    end

endmodule

// File: rtl/rbm_bit_plane.sv
// Module: rbm_bit_plane
// One plane of ROWS x COLS single-bit cells. A one-hot word line picks the
// row. The selected row appears in full on row_bits, and a write changes the
// single cell where the word line and the one-hot column meet.
// Assumes word_line and col_sel are one-hot or zero. The cells have no reset
// and hold undefined values until written.
module rbm_bit_plane #(
    parameter int ROWS = 4,
    parameter int COLS = 4
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [ROWS-1:0] word_line,
    input  logic [COLS-1:0] col_sel,
    input  logic            wr_bit,
    output logic [COLS-1:0] row_bits
);

    logic [COLS-1:0] cells [ROWS];

    // Cell write: only the cell at the active word line and column changes.
    always_ff @(posedge clk) begin : p_cell_write
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (wr_en && word_line[r] && col_sel[c]) begin
                    cells[r][c] <= wr_bit;
                end
            end
        end
    end

    // Row read: the active word line places its whole row on the bit lines.
    always_comb begin : p_row_read
        row_bits = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (word_line[r]) begin
                row_bits = row_bits | cells[r];
            end
        end
    end

endmodule

// File: rtl/rbm_col_select.sv
// Module: rbm_col_select
// Picks one bit from a latched row using a one-hot column select.
// Assumes col_sel is one-hot. An all-zero select gives 0.
module rbm_col_select #(
    parameter int COLS = 4
) (
    input  logic [COLS-1:0] row_bits,
    input  logic [COLS-1:0] col_sel,
    output logic            bit_out
);

    // AND-OR mux over the columns.
    always_comb begin : p_pick
        bit_out = 1'b0;
        for (int c = 0; c < COLS; c++) begin
            bit_out = bit_out | (row_bits[c] & col_sel[c]);
        end
    end

endmodule

// File: rtl/rbm_ctrl.sv
// Module: rbm_ctrl
// Accepts requests, tracks which row sits in the row buffer, and sequences
// reads: a hit returns at the accepting edge, and a miss loads the row
// first and returns one edge later.
// Assumes a synchronous active-low reset. Requests seen while busy are dropped.
module rbm_ctrl
    import rbm_pkg::*;
#(
    parameter int ROW_W = 2,
    parameter int COL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             wr_accept,
    output logic             wr_hit,
    output logic             rd_hit_accept,
    output logic             load_row,
    output logic             read_emit,
    output logic             busy,
    output logic [COL_W-1:0] sel_col
);

    rbm_state_e       state_q;
    logic             buf_valid_q;
    logic [ROW_W-1:0] buf_row_q;
    logic [COL_W-1:0] col_q;
    logic             accept;
    logic             row_match;

    // Request acceptance and classification against the buffered row.
    always_comb begin : p_classify
        busy          = (state_q == RBM_ACTIVATE);
        accept        = req_valid && !busy;
        row_match     = buf_valid_q && (buf_row_q == req_row);
        wr_accept     = accept && req_write;
        wr_hit        = wr_accept && row_match;
        rd_hit_accept = accept && !req_write && row_match;
        load_row      = accept && !req_write && !row_match;
        read_emit     = rd_hit_accept || busy;
        sel_col       = busy ? col_q : req_col;
    end

    // Phase register: a miss spends one cycle in activation.
    always_ff @(posedge clk) begin : p_state
        if (!rst_n) begin
            state_q <= RBM_IDLE;
        end else begin
            unique case (state_q)
                RBM_IDLE:     if (load_row) state_q <= RBM_ACTIVATE;
                RBM_ACTIVATE: state_q <= RBM_IDLE;
                default:      state_q <= RBM_IDLE;
            endcase
        end
    end

    // Buffered-row tracking and the saved column of a pending miss.
    always_ff @(posedge clk) begin : p_track
        if (!rst_n) begin
            buf_valid_q <= 1'b0;
            buf_row_q   <= '0;
            col_q       <= '0;
        end else if (load_row) begin
            buf_valid_q <= 1'b1;
            buf_row_q   <= req_row;
            col_q       <= req_col;
        end
    end

    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy) else $error("busy longer than one cycle"); // R5
    AST_MISS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        load_row |=> busy) else $error("miss did not enter activation"); // R3
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_accept && !rd_hit_accept && !load_row) else $error("request taken while busy"); // R5

endmodule

// File: rtl/rowbuf_mem.sv
// Module: rowbuf_mem (top)
// A memory array of PLANES identical bit planes sharing a row and column
// address. A read latches the whole row into a row buffer, and a column
// select then forms the output word. Writes go straight to the cells and
// keep the buffer coherent.
// Assumes ROWS and COLS are powers of two, at least 2. The array contents are
// undefined after reset.
module rowbuf_mem #(
    parameter  int ROWS   = 4,
    parameter  int COLS   = 4,
    parameter  int PLANES = 2,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PLANES-1:0] req_wdata,
    output logic [PLANES-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy
);

    logic [ROW_W-1:0]             req_row;
    logic [COL_W-1:0]             req_col;
    logic [ROWS-1:0]              word_line;
    logic [COLS-1:0]              wr_col_oh;
    logic [COLS-1:0]              rd_col_oh;
    logic [COL_W-1:0]             sel_col;
    logic                         wr_accept;
    logic                         wr_hit;
    logic                         rd_hit_accept;
    logic                         load_row;
    logic                         read_emit;
    logic [PLANES-1:0][COLS-1:0]  plane_row;
    logic [PLANES-1:0][COLS-1:0]  buf_q;
    logic [PLANES-1:0]            sel_bits;

    // Address split: row field above column field.
    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    rbm_ctrl #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_row       (req_row),
        .req_col       (req_col),
        .wr_accept     (wr_accept),
        .wr_hit        (wr_hit),
        .rd_hit_accept (rd_hit_accept),
        .load_row      (load_row),
        .read_emit     (read_emit),
        .busy          (busy),
        .sel_col       (sel_col)
    );

    rbm_onehot_decoder #(.N(ROWS)) u_row_dec (
        .idx (req_row),
        .sel (word_line)
    );

    rbm_onehot_decoder #(.N(COLS)) u_wr_col_dec (
        .idx (req_col),
        .sel (wr_col_oh)
    );

    rbm_onehot_decoder #(.N(COLS)) u_rd_col_dec (
        .idx (sel_col),
        .sel (rd_col_oh)
    );

    // Bit planes and their column selectors, one pair per data bit.
    generate
        for (genvar p = 0; p < PLANES; p++) begin : g_plane
            rbm_bit_plane #(
                .ROWS (ROWS),
                .COLS (COLS)
            ) u_plane (
                .clk       (clk),
                .wr_en     (wr_accept),
                .word_line (word_line),
                .col_sel   (wr_col_oh),
                .wr_bit    (req_wdata[p]),
                .row_bits  (plane_row[p])
            );

            rbm_col_select #(.COLS(COLS)) u_col_sel (
                .row_bits (buf_q[p]),
                .col_sel  (rd_col_oh),
                .bit_out  (sel_bits[p])
            );

            AST_BUF_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hit |=> buf_q[p][$past(req_col)] == $past(req_wdata[p])) else $error("row buffer stale"); // R7
        end
    endgenerate

    // Row buffer: loaded whole on activation, patched by writes to its row.
    always_ff @(posedge clk) begin : p_row_buffer
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            for (int p = 0; p < PLANES; p++) begin
                if (load_row) begin
                    buf_q[p] <= plane_row[p];
                end else if (wr_hit) begin
                    for (int c = 0; c < COLS; c++) begin
                        if (wr_col_oh[c]) buf_q[p][c] <= req_wdata[p];
                    end
                end
            end
        end
    end

    // Read output register: one-cycle strobe with the column-selected word.
    always_ff @(posedge clk) begin : p_read_out
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= read_emit;
            if (read_emit) rd_data <= sel_bits;
        end
    end

    AST_MISS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> rd_valid) else $error("miss did not return"); // R3
    AST_HIT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_accept |=> rd_valid) else $error("hit did not return"); // R4
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> !rd_valid) else $error("write raised rd_valid"); // R9

endmodule

// File: tb/rowbuf_mem_tb.sv
`timescale 1ns/1ps
module rowbuf_mem_tb;

    localparam int ROWS   = 8;
    localparam int COLS   = 4;
    localparam int PLANES = 8;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int COL_W  = $clog2(COLS);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int NADDR  = ROWS * COLS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [PLANES-1:0] req_wdata = '0;
    logic [PLANES-1:0] rd_data;
    logic              rd_valid;
    logic              busy;

    always #2.5 clk = ~clk;

    rowbuf_mem #(.ROWS(ROWS), .COLS(COLS), .PLANES(PLANES)) u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .rd_data (rd_data),
        .rd_valid (rd_valid), .busy (busy)
    );

    int                n_chk  = 0;
    int                n_fail = 0;
    logic [PLANES-1:0] model [NADDR];
    bit                m_buf_valid = 1'b0;
    int                m_buf_row   = 0;

    function automatic int row_of(int a);
        return a / COLS;
    endfunction

    function automatic int exp_latency(int a);
        return (m_buf_valid && row_of(a) == m_buf_row) ? 1 : 2;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Write one word; starts and ends at a negative edge.
    task automatic do_write(int a, logic [PLANES-1:0] d);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = ADDR_W'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R9", "rd_valid after write", int'(rd_valid), 0);
        model[a] = d;
    endtask

    // Read one word and check latency against the bench's buffer model.
    task automatic do_read(int a, string tag);
        int lat = exp_latency(a);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(a);
        @(negedge clk);
        req_valid = 1'b0;
        if (lat == 1) begin
            check({tag, "/R4"}, "hit rd_valid", int'(rd_valid), 1);
            check({tag, "/R6"}, "hit data", int'(rd_data), int'(model[a]));
        end else begin
            check({tag, "/R3"}, "miss early rd_valid", int'(rd_valid), 0);
            check({tag, "/R5"}, "miss busy", int'(busy), 1);
            @(negedge clk);
            check({tag, "/R3"}, "miss rd_valid", int'(rd_valid), 1);
            check({tag, "/R6"}, "miss data", int'(rd_data), int'(model[a]));
            check({tag, "/R5"}, "busy cleared", int'(busy), 0);
            m_buf_valid = 1'b1;
            m_buf_row   = row_of(a);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_buf_valid = 1'b0;
        check("R8", "rd_valid after reset", int'(rd_valid), 0);
        check("R8", "busy after reset", int'(busy), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        @(negedge clk);
        apply_reset();

        // R2/R6: fill every address with unique data, read all back.
        for (int a = 0; a < NADDR; a++) do_write(a, PLANES'(a * 7 + 3));
        do_read(5, "R8");                        // first read after reset misses
        for (int a = 0; a < NADDR; a++) do_read(a, "R2");

        // R1: low bits share a row, so columns of one row hit after one miss.
        do_read(2 * COLS + 1, "R1");
        check("R1", "same-row latency", exp_latency(2 * COLS + 3), 1);
        do_read(2 * COLS + 3, "R1");
        do_read(2 * COLS + 0, "R1");
        @(negedge clk);
        check("R9", "rd_valid idle", int'(rd_valid), 0);

        // R7: write into buffered row, then read it as a hit with new data.
        do_write(2 * COLS + 3, 8'hA5);
        do_read(2 * COLS + 3, "R7");

        // R10: write another row; buffered row stays a hit.
        do_write(6 * COLS + 1, 8'h3C);
        do_read(2 * COLS + 2, "R10");
        do_read(6 * COLS + 1, "R10");

        // R5: requests during busy are ignored.
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(1 * COLS + 2);
        @(negedge clk);
        check("R5", "busy during miss", int'(busy), 1);
        req_write = 1'b1; req_addr = ADDR_W'(7 * COLS + 0); req_wdata = 8'hFF;
        @(negedge clk);
        check("R3", "miss return", int'(rd_valid), 1);
        check("R6", "miss data", int'(rd_data), int'(model[1 * COLS + 2]));
        req_write = 1'b0; req_addr = ADDR_W'(1 * COLS + 0);
        m_buf_valid = 1'b1; m_buf_row = 1;
        // read accepted here is a hit on row 1 (busy now low)
        @(negedge clk);
        req_valid = 1'b0;
        check("R4", "hit after busy", int'(rd_valid), 1);
        do_read(7 * COLS + 0, "R5");             // dropped write left old value

        // R5: a read during busy gives no extra strobe.
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(4 * COLS + 1);
        @(negedge clk);
        req_addr = ADDR_W'(4 * COLS + 2);
        @(negedge clk);
        req_valid = 1'b0;
        m_buf_valid = 1'b1; m_buf_row = 4;
        @(negedge clk);
        check("R5", "no strobe for dropped read", int'(rd_valid), 0);

        // R8: reset mid-run forgets the buffered row.
        do_read(4 * COLS + 3, "R8");
        apply_reset();
        do_read(4 * COLS + 3, "R8");

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            int a = int'($urandom % NADDR);
            if ($urandom % 3 == 0) do_write(a, PLANES'($urandom));
            else do_read(a, "RND");
        end

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule